// File: doc/BRIEF.md
# Strobe-Qualified Source-Synchronous Capture Engine

This block collects data from a bus on which each data lane travels with its own strobe, and delivers one merged sample word in the master clock domain. Four clock and strobe lines are brought into the master domain through two-stage synchronizers. Each line feeds an edge detector that can be set to react to rising edges, falling edges or both. Edge detectors are bound into clock groups. A group completes its event only after every detector assigned to it has fired. On completion, the group latches its own data lane and holds it.

The completed groups wait for a final enabling event. That event is the rising edge of a programmable sample equation: an OR of product terms over group-completion flags and qualifier inputs. When it occurs, all held lanes are released together as one word with a single-cycle valid pulse. All completion state is then cleared, so that a partly seen group cannot carry stale edges into the next sample. A repeated edge before completion, or a second completion before release, sets a sticky per-group overrun flag. In that case the first latched value is kept.

Configuration goes through a small write-only register port. Detectors, groups and terms share one address space, laid out in that order.

Top module: `ssc_capture`

## Requirements
- R1: After reset, `smp_valid` is 0, `smp_data` is 0 and `overrun` is 0.
- R2: Detector i is configured at address i. Write-data bit 0 enables rising edges and bit 1 enables falling edges. A detector reacts only to the edges enabled for it, and with both bits set it fires on each edge.
- R3: Group g has a detector mask at address 4+g, with bit i selecting detector i. The group completes only when every masked detector has fired since the last completion or release. A group with an empty mask never completes.
- R4: On completion, group g latches lane g of `data_in` (bits g*16+15 down to g*16) and holds it. Later changes of `data_in` do not change the held value.
- R5: A release outputs all held lanes together in one word, with lane g in bits g*16+15 down to g*16. Nothing is released until the sample equation becomes true.
- R6: Term t is selected at address 6+t. Its literal bits are: bit 0 = group 0 done, bit 1 = group 1 done, bit 2 = qual[0], bit 3 = qual[1]. A term is true when all of its selected literals are true. The equation is the OR of the terms, and a release happens on each rising edge of the equation.
- R7: A release clears every group's seen edges and done flag, so edges seen before a release never count toward a later completion.
- R8: Overrun bit g becomes 1 and stays 1 until reset when a masked detector fires again before group g completes, or when group g completes again before a release. In that case the first held value is the one released.
- R9: `smp_valid` is high for one cycle per release. `smp_data` changes only in a cycle where `smp_valid` is high.
- R10: A term whose select is all zeros is never true. With both terms zero, completed groups stay held and no release occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | 4 | Configuration write data |
| edge_src | input | 4 | Clock and strobe lines, one per detector |
| data_in | input | 32 | Data lanes, 16 bits per group |
| qual | input | 2 | Qualifier signals for the sample equation |
| smp_valid | output | 1 | One-cycle pulse marking a released sample |
| smp_data | output | 32 | Merged sample word |
| overrun | output | 2 | Sticky per-group overrun flags |

## Verification
A group's seen-edge state that fails to clear shows up as an extra or early `smp_valid` within about four cycles of the next single strobe edge. A held lane that is overwritten appears as the wrong half of `smp_data` on the next release. A wrong edge-enable decode shows as a missing or doubled pulse on the edge that follows the strobe transition. Equation faults show within three cycles of a qualifier change, as a release that is absent, repeated or spurious. The overrun flag is visible directly on the port as soon as the repeated edge is detected.

// File: rtl/ssc_pkg.sv
// Shared sizing for the source-synchronous capture engine.
// Assumes the configuration map fits detectors, groups and terms in order.
package ssc_pkg;
    localparam int NUM_DET  = 4;
    localparam int NUM_GRP  = 2;
    localparam int GRP_W    = 16;
    localparam int NUM_QUAL = 2;
    localparam int NUM_TERM = 2;
    localparam int NUM_LIT  = NUM_GRP + NUM_QUAL;
    localparam int NUM_REG  = NUM_DET + NUM_GRP + NUM_TERM;
    localparam int CFG_AW   = $clog2(NUM_REG);
    localparam int CFG_DW   = (NUM_DET > NUM_LIT) ? NUM_DET : NUM_LIT;
endpackage

// File: rtl/ssc_sync.sv
// Two-stage synchronizer bank into the master clock domain.
// Assumes each bit is sampled independently; multi-bit data is expected
// to be stable around the strobe edge that qualifies it.
module ssc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ssc_edge_det.sv
// Edge detectors on synchronized lines: one-cycle hit per enabled edge.
// Assumes inputs are already in the master domain.
module ssc_edge_det #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    output logic [N-1:0] hit
);
    logic [N-1:0] line_d;

    // Remember the previous level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_d <= '0;
        else        line_d <= line;
    end

    // Combine edge type with its enable.
    always_comb begin
        hit = (line & ~line_d & rise_en) | (~line & line_d & fall_en);
    end
endmodule

// File: rtl/ssc_clk_group.sv
// One clock group: gathers masked detector hits, completes when all are
// seen, latches and holds its data lane until cleared by a release.
// Assumes clear has priority over any completion in the same cycle.
module ssc_clk_group #(
    parameter int NDET = 4,
    parameter int W    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NDET-1:0] hit,
    input  logic [NDET-1:0] mask,
    input  logic [W-1:0]    data,
    input  logic            clear,
    output logic            done,
    output logic [W-1:0]    hold,
    output logic            ovr
);
    logic [NDET-1:0] seen;
    logic [NDET-1:0] seen_nx;
    logic            cmpl;
    logic            again;

    // Completion and repeat detection.
    always_comb begin
        seen_nx = seen | (hit & mask);
        cmpl    = (mask != '0) && ((seen_nx & mask) == mask);
        again   = |(hit & mask & seen);
    end

    // Seen set, done flag and held lane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= '0;
            done <= 1'b0;
            hold <= '0;
        end else if (clear) begin
            seen <= '0;
            done <= 1'b0;
        end else if (cmpl) begin
            seen <= '0;
            done <= 1'b1;
            if (!done) hold <= data;
        end else begin
            seen <= seen_nx;
        end
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) ovr <= 1'b0;
        else if (again || (cmpl && done)) ovr <= 1'b1;
    end
endmodule

// File: rtl/ssc_sample_eq.sv
// Sample equation: OR of product terms over literals; fires on its
// rising edge. Assumes an all-zero term select means the term is off.
module ssc_sample_eq #(
    parameter int NLIT  = 4,
    parameter int NTERM = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NLIT-1:0]            lits,
    input  logic [NTERM-1:0][NLIT-1:0] sel,
    output logic                       fire
);
    logic [NTERM-1:0] term;
    logic             eq;
    logic             eq_d;

    // Product terms.
    for (genvar t = 0; t < NTERM; t++) begin : g_term
        assign term[t] = (sel[t] != '0) && ((lits & sel[t]) == sel[t]);
    end

    // Sum of terms.
    always_comb eq = |term;

    // Previous equation value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_d <= 1'b0;
        else        eq_d <= eq;
    end

    // Rising edge of the equation.
    always_comb fire = eq & ~eq_d;
endmodule

// File: rtl/ssc_capture.sv
// Top of the capture engine: configuration registers, synchronizers,
// edge detectors, clock groups, sample equation and output register.
// Assumes all lines are slow enough to be oversampled by the master clock.
module ssc_capture
    import ssc_pkg::*;
#(
    parameter int N_DET  = NUM_DET,
    parameter int N_GRP  = NUM_GRP,
    parameter int LANE_W = GRP_W,
    parameter int N_QUAL = NUM_QUAL,
    parameter int N_TERM = NUM_TERM,
    parameter int AW     = CFG_AW,
    parameter int DW     = CFG_DW
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [AW-1:0]           cfg_addr,
    input  logic [DW-1:0]           cfg_wdata,
    input  logic [N_DET-1:0]        edge_src,
    input  logic [N_GRP*LANE_W-1:0] data_in,
    input  logic [N_QUAL-1:0]       qual,
    output logic                    smp_valid,
    output logic [N_GRP*LANE_W-1:0] smp_data,
    output logic [N_GRP-1:0]        overrun
);
    localparam int NLIT  = N_GRP + N_QUAL;
    localparam int GBASE = N_DET;
    localparam int TBASE = N_DET + N_GRP;

    logic [N_DET-1:0]                rise_en, fall_en;
    logic [N_GRP-1:0][N_DET-1:0]     grp_mask;
    logic [N_TERM-1:0][NLIT-1:0]     term_sel;
    logic [N_DET-1:0]                src_s, hit;
    logic [N_GRP*LANE_W-1:0]         data_s;
    logic [N_QUAL-1:0]               qual_s;
    logic [N_GRP-1:0]                grp_done;
    logic [N_GRP-1:0][LANE_W-1:0]    grp_hold;
    logic                            fire;

    // Configuration register writes, decoded by address range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_en  <= '0;
            fall_en  <= '0;
            grp_mask <= '0;
            term_sel <= '0;
        end else if (cfg_we) begin
            for (int i = 0; i < N_DET; i++) begin
                if (cfg_addr == AW'(i)) begin
                    rise_en[i] <= cfg_wdata[0];
                    fall_en[i] <= cfg_wdata[1];
                end
            end
            for (int g = 0; g < N_GRP; g++) begin
                if (cfg_addr == AW'(GBASE + g)) grp_mask[g] <= cfg_wdata[N_DET-1:0];
            end
            for (int t = 0; t < N_TERM; t++) begin
                if (cfg_addr == AW'(TBASE + t)) term_sel[t] <= cfg_wdata[NLIT-1:0];
            end
        end
    end

    ssc_sync #(.W(N_DET)) i_sync_src (
        .clk(clk), .rst_n(rst_n), .d(edge_src), .q(src_s)
    );
    ssc_sync #(.W(N_GRP*LANE_W)) i_sync_data (
        .clk(clk), .rst_n(rst_n), .d(data_in), .q(data_s)
    );
    ssc_sync #(.W(N_QUAL)) i_sync_qual (
        .clk(clk), .rst_n(rst_n), .d(qual), .q(qual_s)
    );

    ssc_edge_det #(.N(N_DET)) i_edge (
        .clk(clk), .rst_n(rst_n), .line(src_s),
        .rise_en(rise_en), .fall_en(fall_en), .hit(hit)
    );

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        ssc_clk_group #(.NDET(N_DET), .W(LANE_W)) i_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit),
            .mask  (grp_mask[g]),
            .data  (data_s[g*LANE_W +: LANE_W]),
            .clear (fire),
            .done  (grp_done[g]),
            .hold  (grp_hold[g]),
            .ovr   (overrun[g])
        );
    end

    ssc_sample_eq #(.NLIT(NLIT), .NTERM(N_TERM)) i_eq (
        .clk(clk), .rst_n(rst_n), .lits({qual_s, grp_done}),
        .sel(term_sel), .fire(fire)
    );

    // Output register: merged word and one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= fire;
            if (fire) smp_data <= grp_hold;
        end
    end
endmodule

// File: rtl/ssc_capture_chk.sv
// Property checker for ssc_capture, attached by bind below.
// Assumes reset is asserted for at least one clock at start.
module ssc_capture_chk #(
    parameter int DW = 32,
    parameter int NG = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          smp_valid,
    input logic [DW-1:0] smp_data,
    input logic [NG-1:0] overrun,
    input logic [NG-1:0] grp_done
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> !smp_valid); // R9
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> $stable(smp_data)); // R9
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun & $past(overrun)) == $past(overrun)); // R8
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (grp_done == '0)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        !$past(rst_n) |-> (!smp_valid && overrun == '0)); // R1
endmodule

bind ssc_capture ssc_capture_chk #(.DW(N_GRP*LANE_W), .NG(N_GRP)) i_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .overrun(overrun), .grp_done(grp_done)
);

// File: tb/test_ssc_capture.sv
// Directed bench for ssc_capture: one task per scenario.
module test_ssc_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [3:0]  cfg_wdata = '0;
    logic [3:0]  edge_src = '0;
    logic [31:0] data_in = '0;
    logic [1:0]  qual = '0;
    logic        smp_valid;
    logic [31:0] smp_data;
    logic [1:0]  overrun;

    int checks = 0;
    int failures = 0;
    int vcnt = 0;
    int pulse_err = 0;
    logic [31:0] vdata = '0;
    logic prev_v = 1'b0;

    ssc_capture i_ssc_capture (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .edge_src(edge_src), .data_in(data_in),
        .qual(qual), .smp_valid(smp_valid), .smp_data(smp_data),
        .overrun(overrun)
    );

    always #10 clk = ~clk;

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (smp_valid) begin
            vcnt++;
            vdata = smp_data;
            if (prev_v) pulse_err++;
        end
        prev_v = smp_valid;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_wdata = 4'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // High then low on one source line.
    task automatic pulse(input int i);
        @(negedge clk); edge_src[i] = 1'b1; wait_cyc(6);
        edge_src[i] = 1'b0; wait_cyc(6);
    endtask

    task automatic t_reset;
        check("R1 valid", 32'(smp_valid), 32'd0);
        check("R1 data", smp_data, 32'd0);
        check("R1 overrun", 32'(overrun), 32'd0);
    endtask

    task automatic t_edge_sel;
        int base;
        cfg_wr(0, 2); cfg_wr(1, 1); cfg_wr(2, 1); cfg_wr(3, 1);
        cfg_wr(4, 4'b0001); cfg_wr(5, 0); cfg_wr(6, 4'b0001); cfg_wr(7, 0);
        data_in = 32'h0000_1111;
        base = vcnt;
        @(negedge clk); edge_src[0] = 1'b1; wait_cyc(6);
        check("R2 rise ignored when fall only", 32'(vcnt - base), 32'd0);
        edge_src[0] = 1'b0; wait_cyc(6);
        check("R2 fall fires", 32'(vcnt - base), 32'd1);
        check("R2 data", vdata, 32'h0000_1111);
        cfg_wr(0, 3);
        base = vcnt;
        pulse(0);
        check("R2 both edges", 32'(vcnt - base), 32'd2);
    endtask

    task automatic t_empty_term;
        int base;
        cfg_wr(0, 1); cfg_wr(6, 0); cfg_wr(7, 0);
        data_in = 32'h0000_2222;
        base = vcnt;
        pulse(0);
        check("R10 zero terms never release", 32'(vcnt - base), 32'd0);
        cfg_wr(6, 4'b0001); wait_cyc(6);
        check("R10 held group released once term set", 32'(vcnt - base), 32'd1);
        check("R4 held lane", vdata[15:0], 32'h2222);
    endtask

    task automatic t_all_edges;
        int base;
        cfg_wr(4, 4'b0011);
        base = vcnt;
        pulse(0);
        check("R3 partial group no release", 32'(vcnt - base), 32'd0);
        pulse(1);
        check("R3 complete group releases", 32'(vcnt - base), 32'd1);
    endtask

    task automatic t_stale;
        int base;
        cfg_wr(4, 4'b0001); cfg_wr(5, 4'b0110);
        cfg_wr(6, 4'b0001); cfg_wr(7, 4'b0010);
        base = vcnt;
        pulse(1);
        check("R7 group1 partial", 32'(vcnt - base), 32'd0);
        pulse(0);
        check("R7 group0 release", 32'(vcnt - base), 32'd1);
        pulse(2);
        check("R7 stale edge cleared", 32'(vcnt - base), 32'd1);
        pulse(1);
        check("R7 fresh pair completes", 32'(vcnt - base), 32'd2);
    endtask

    task automatic t_merge;
        int base;
        cfg_wr(4, 4'b0001); cfg_wr(5, 4'b0010);
        cfg_wr(6, 4'b0011); cfg_wr(7, 0);
        base = vcnt;
        data_in = 32'hBBBB_AAAA;
        pulse(0);
        check("R5 wait for all groups", 32'(vcnt - base), 32'd0);
        data_in = 32'hCCCC_DDDD;
        pulse(1);
        check("R5 one release", 32'(vcnt - base), 32'd1);
        check("R4 R5 merged word", vdata, 32'hCCCC_AAAA);
    endtask

    task automatic t_equation;
        int base;
        cfg_wr(6, 4'b0101); cfg_wr(7, 4'b1000);
        qual = 2'b00;
        base = vcnt;
        pulse(0);
        check("R6 AND term needs qualifier", 32'(vcnt - base), 32'd0);
        qual[0] = 1'b1; wait_cyc(6);
        check("R6 AND term true", 32'(vcnt - base), 32'd1);
        qual[0] = 1'b0; wait_cyc(2);
        qual[1] = 1'b1; wait_cyc(6);
        check("R6 OR term true", 32'(vcnt - base), 32'd2);
        wait_cyc(10);
        check("R6 only rising edge releases", 32'(vcnt - base), 32'd2);
        qual[1] = 1'b0; wait_cyc(4);
    endtask

    task automatic t_overrun;
        int base;
        cfg_wr(6, 4'b0101); cfg_wr(7, 0);
        cfg_wr(4, 4'b0001); cfg_wr(5, 4'b0110);
        qual = 2'b00; wait_cyc(4);
        base = vcnt;
        data_in = 32'h0000_1234;
        pulse(0);
        check("R8 no flag yet", 32'(overrun), 32'd0);
        data_in = 32'h0000_5678;
        pulse(0);
        check("R8 second completion flags", 32'(overrun), 32'b01);
        qual[0] = 1'b1; wait_cyc(6);
        check("R8 release count", 32'(vcnt - base), 32'd1);
        check("R8 first value kept", vdata[15:0], 32'h1234);
        pulse(1); pulse(1);
        check("R8 repeated edge flags, sticky", 32'(overrun), 32'b11);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_edge_sel();
        t_empty_term();
        t_all_edges();
        t_stale();
        t_merge();
        t_equation();
        t_overrun();
        check("R9 single-cycle valid", 32'(pulse_err), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule